// File: doc/BRIEF.md
# Interleaved I/Q Serial Frame Receiver

This block is the clock master of a synchronous serial link. Over that link a DSP delivers baseband modulation samples to a converter. The block divides its system clock down to a serial bit clock and sends that clock to the DSP. At the start of every frame it raises a frame-sync strobe. It then shifts in two back-to-back 16-bit two's-complement words, the in-phase word first and the quadrature word second, and presents them together as one parallel pair with a one-cycle valid strobe. The downstream sample-rate filter consumes that pair.

The link is driven only while a transmit-enable input is high. When enable rises, the next falling bit-clock edge opens the first frame. Frames then follow one another with no idle bit periods. If enable drops, the frame in progress is abandoned and its bits are never presented. The parameter `CLK_DIV` sets the system-clock to bit-clock ratio and must be even. The parameter `WORD_W` sets the width of each word.

Top module: `iq_serial_rx`

## Requirements
- R1: While reset is asserted and right after it, the outputs are as follows: bit clock low, frame sync low, valid low, and both parallel words zero.
- R2: The bit clock is the system clock divided by `CLK_DIV` with equal high and low halves. After reset it stays low for `CLK_DIV/2` system cycles before its first rise.
- R3: While transmit-enable is low, frame sync and valid stay low, one system cycle after enable is sampled low.
- R4: With enable high, a frame begins on a falling bit-clock edge, and frame sync rises on that edge. Frame sync stays high for exactly one bit period and falls on the next falling edge.
- R5: On each falling bit-clock edge after the sync period, the receiver samples the serial input once. The first `WORD_W` bits form the in-phase word, most significant bit first. The next `WORD_W` bits form the quadrature word, most significant bit first, with no gap between the words.
- R6: In the system cycle after the falling edge that samples the last quadrature bit, valid is high for exactly one cycle. Both words update together in that cycle, and they hold their values in every other cycle.
- R7: While enable stays high, the next frame's sync period starts on the same falling edge that samples the last quadrature bit, so frames run back to back.
- R8: Dropping enable at any point in a frame, including its final bit period, discards that frame. No valid pulse is produced for it, the previous pair stays on the outputs, and the next frame starts afresh with a new sync period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit-enable; high lets frames run |
| sdata_i | input | 1 | Serial sample data from the DSP |
| bclk_o | output | 1 | Serial bit clock sent to the DSP |
| fsync_o | output | 1 | Frame-sync strobe, high during the bit period before the in-phase MSB |
| i_word_o | output | WORD_W | Parallel in-phase word |
| q_word_o | output | WORD_W | Parallel quadrature word |
| pair_valid_o | output | 1 | One-cycle strobe marking a new I/Q pair |

## Verification
The hardest case to reach is an abort in the final bit period. There, enable falls after the last quadrature bit has been driven but before the falling edge that would sample it. The bench follows the frame position in its own reference model. It waits until that model reports the last slot and then lowers enable at once. This also checks that the pulse is dropped, not delayed. The bench aborts a second frame in the middle and compares every cycle against the reference, so the restart after each abort must open with a fresh sync period.

// File: rtl/iq_rx_pkg.sv
package iq_rx_pkg;

    typedef enum logic {
        LINK_IDLE = 1'b0,
        LINK_RUN  = 1'b1
    } link_st_e;

endpackage

// File: rtl/iq_rx_bclk_gen.sv
module iq_rx_bclk_gen #(
    parameter int CLK_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic bclk_o,
    output logic fall_evt_o
);
    localparam int HALF = CLK_DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          bclk;
    } div_s;

    div_s div_d, div_q;

    generate
        if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
            $error("CLK_DIV must be even and at least 2");
        end
    endgenerate

    always_comb begin
        div_d = div_q;
        if (div_q.cnt == LAST) begin
            div_d.cnt  = '0;
            div_d.bclk = ~div_q.bclk;
        end else begin
            div_d.cnt = div_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign bclk_o     = div_q.bclk;
    assign fall_evt_o = div_q.bclk && (div_q.cnt == LAST);

    // R2: once the clock rises it must stay high for the rest of its half period
    assert_no_early_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bclk_o) && (HALF > 1) |=> bclk_o);

endmodule

// File: rtl/iq_rx_frame_ctl.sv
module iq_rx_frame_ctl
    import iq_rx_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic fall_evt,
    output logic fsync_o,
    output logic shift_en_o,
    output logic last_bit_o
);
    localparam int SLOTS = 2 * WORD_W;
    localparam int SW    = $clog2(SLOTS + 1);
    localparam logic [SW-1:0] LAST_SLOT = SW'(SLOTS);

    typedef struct packed {
        link_st_e      st;
        logic [SW-1:0] slot;
        logic          fsync;
    } ctl_s;

    ctl_s ctl_d, ctl_q;
    logic shift_en, last_bit;

    always_comb begin
        ctl_d    = ctl_q;
        shift_en = 1'b0;
        last_bit = 1'b0;
        if (!tx_en) begin
            ctl_d.st    = LINK_IDLE;
            ctl_d.slot  = '0;
            ctl_d.fsync = 1'b0;
        end else if (fall_evt) begin
            if (ctl_q.st == LINK_IDLE) begin
                ctl_d.st    = LINK_RUN;
                ctl_d.slot  = '0;
                ctl_d.fsync = 1'b1;
            end else begin
                shift_en = (ctl_q.slot != '0);
                if (ctl_q.slot == LAST_SLOT) begin
                    last_bit    = 1'b1;
                    ctl_d.slot  = '0;
                    ctl_d.fsync = 1'b1;
                end else begin
                    ctl_d.slot  = ctl_q.slot + SW'(1);
                    ctl_d.fsync = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: LINK_IDLE, slot: '0, fsync: 1'b0};
        else        ctl_q <= ctl_d;
    end

    assign fsync_o    = ctl_q.fsync;
    assign shift_en_o = shift_en;
    assign last_bit_o = last_bit;

    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> !fsync_o);

    assert_sync_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fsync_o) |-> $past(fall_evt));

    assert_sync_one_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fsync_o && fall_evt |=> !fsync_o);

endmodule

// File: rtl/iq_rx_sipo.sv
module iq_rx_sipo #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sdata,
    input  logic              shift_en,
    input  logic              last_bit,
    output logic [WORD_W-1:0] i_o,
    output logic [WORD_W-1:0] q_o,
    output logic              valid_o
);
    localparam int FW = 2 * WORD_W;

    typedef struct packed {
        logic [FW-1:0]     sh;
        logic [WORD_W-1:0] i;
        logic [WORD_W-1:0] q;
        logic              vld;
    } sipo_s;

    sipo_s sp_d, sp_q;
    logic [FW-1:0] shifted;

    always_comb begin
        sp_d     = sp_q;
        shifted  = {sp_q.sh[FW-2:0], sdata};
        sp_d.vld = last_bit;
        if (shift_en) sp_d.sh = shifted;
        if (last_bit) begin
            sp_d.i = shifted[FW-1:WORD_W];
            sp_d.q = shifted[WORD_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sp_q <= '0;
        else        sp_q <= sp_d;
    end

    assign i_o     = sp_q.i;
    assign q_o     = sp_q.q;
    assign valid_o = sp_q.vld;

    assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

endmodule

// File: rtl/iq_serial_rx.sv
module iq_serial_rx #(
    parameter int CLK_DIV = 8,
    parameter int WORD_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              sdata_i,
    output logic              bclk_o,
    output logic              fsync_o,
    output logic [WORD_W-1:0] i_word_o,
    output logic [WORD_W-1:0] q_word_o,
    output logic              pair_valid_o
);
    logic fall_evt, shift_en, last_bit;

    iq_rx_bclk_gen #(.CLK_DIV(CLK_DIV)) u_bclk (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk_o    (bclk_o),
        .fall_evt_o(fall_evt)
    );

    iq_rx_frame_ctl #(.WORD_W(WORD_W)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en     (tx_en),
        .fall_evt  (fall_evt),
        .fsync_o   (fsync_o),
        .shift_en_o(shift_en),
        .last_bit_o(last_bit)
    );

    iq_rx_sipo #(.WORD_W(WORD_W)) u_sipo (
        .clk     (clk),
        .rst_n   (rst_n),
        .sdata   (sdata_i),
        .shift_en(shift_en),
        .last_bit(last_bit),
        .i_o     (i_word_o),
        .q_o     (q_word_o),
        .valid_o (pair_valid_o)
    );

    assert_valid_after_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid_o |-> $fell(bclk_o));

    assert_back_to_back_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid_o |-> fsync_o);

    assert_pair_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_valid_o |-> $stable(i_word_o) && $stable(q_word_o));

    assert_no_valid_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> !pair_valid_o);

endmodule

// File: tb/iq_serial_rx_bench.sv
module iq_serial_rx_bench;
    localparam int CLK_DIV = 8;
    localparam int WORD_W  = 16;
    localparam int HALF    = CLK_DIV / 2;
    localparam int FB      = 2 * WORD_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_en = 1'b0;
    logic sdata = 1'b0;
    logic bclk, fsync, vld;
    logic [WORD_W-1:0] iw, qw;

    always #2.5 clk = ~clk;

    iq_serial_rx #(.CLK_DIV(CLK_DIV), .WORD_W(WORD_W)) u_iq_serial_rx (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .sdata_i(sdata),
        .bclk_o(bclk), .fsync_o(fsync), .i_word_o(iw), .q_word_o(qw),
        .pair_valid_o(vld)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int obs_vld = 0;

    // reference model state
    int m = 0;
    bit r_act = 0;
    int r_slot = 0;
    int fidx = 0;
    logic [FB-1:0] r_pat = '0;
    logic [FB-1:0] done_pat = '0;
    logic [FB-1:0] r_sh = '0;
    logic e_bclk = 0, e_fs = 0, e_vld = 0;
    logic [WORD_W-1:0] e_i = '0, e_q = '0;

    function automatic logic [FB-1:0] pat(input int k);
        logic [15:0] kk;
        kk = k[15:0];
        case (k % 4)
            0: pat = 32'h8000_7FFF;
            1: pat = 32'h0001_FFFE;
            2: pat = 32'hA5C3_3C5A;
            default: pat = {kk * 16'h9E37, ~(kk * 16'h79B9)};
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m = 0; r_act = 0; r_slot = 0;
            e_bclk = 0; e_fs = 0; e_vld = 0; e_i = '0; e_q = '0;
        end else begin
            m++;
            e_bclk = ((m / HALF) % 2) == 1;
            e_vld = 0;
            if (!tx_en) begin
                r_act = 0; r_slot = 0; e_fs = 0;
            end else if (m % CLK_DIV == 0) begin
                if (!r_act) begin
                    r_act = 1; r_slot = 0; e_fs = 1;
                    r_pat = pat(fidx); fidx++;
                end else begin
                    if (r_slot >= 1) r_sh = {r_sh[FB-2:0], sdata};
                    if (r_slot == FB) begin
                        e_i = r_sh[FB-1:WORD_W]; e_q = r_sh[WORD_W-1:0];
                        e_vld = 1; done_pat = r_pat;
                        r_slot = 0; e_fs = 1;
                        r_pat = pat(fidx); fidx++;
                    end else begin
                        r_slot++; e_fs = 0;
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        chk(bclk === e_bclk, "R2", "bclk", 32'(bclk), 32'(e_bclk));
        chk(fsync === e_fs, "R4", "fsync", 32'(fsync), 32'(e_fs));
        chk(vld === e_vld, "R6", "valid", 32'(vld), 32'(e_vld));
        chk(iw === e_i && qw === e_q, "R6", "pair", {iw, qw}, {e_i, e_q});
        if (vld) begin
            obs_vld++;
            chk({iw, qw} === done_pat, "R5", "msb-first I then Q", {iw, qw}, done_pat);
        end
        if (r_act && r_slot >= 1) sdata <= r_pat[FB - r_slot];
        else                      sdata <= m[2];
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            chk(1'b0, "R5", "watchdog expired", 32'(cyc), 32'd150000);
            finish_run();
        end
    end

    task automatic wait_pairs(input int n);
        int target;
        target = obs_vld + n;
        while (obs_vld < target) @(negedge clk);
    endtask

    initial begin
        int v0;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(bclk === 1'b0 && fsync === 1'b0 && vld === 1'b0, "R1", "ctl outs in reset",
            {29'd0, bclk, fsync, vld}, 32'd0);
        chk(iw === '0 && qw === '0, "R1", "pair in reset", {iw, qw}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bclk === 1'b0 && iw === '0, "R1", "just after reset", {bclk, 31'(iw)}, 32'd0);

        // R3: idle with enable low
        v0 = obs_vld;
        repeat (80) @(negedge clk);
        chk(obs_vld == v0, "R3", "no valid while disabled", 32'(obs_vld), 32'(v0));

        // R4 R5 R6 R7: run several back-to-back frames
        tx_en = 1'b1;
        wait_pairs(4);

        // R8: abort mid-frame
        while (!(r_act && r_slot == 20)) @(negedge clk);
        tx_en = 1'b0;
        v0 = obs_vld;
        repeat (3 * CLK_DIV) @(negedge clk);
        chk(obs_vld == v0, "R8", "mid-frame abort gives no valid", 32'(obs_vld), 32'(v0));
        tx_en = 1'b1;
        wait_pairs(2);

        // R8: abort in the final bit period
        while (!(r_act && r_slot == FB)) @(negedge clk);
        tx_en = 1'b0;
        v0 = obs_vld;
        repeat (2 * CLK_DIV) @(negedge clk);
        chk(obs_vld == v0, "R8", "last-slot abort gives no valid", 32'(obs_vld), 32'(v0));
        chk({iw, qw} === done_pat, "R8", "previous pair held", {iw, qw}, done_pat);
        tx_en = 1'b1;
        wait_pairs(2);

        repeat (10) @(negedge clk);
        finish_run();
    end

endmodule